// File: doc/BRIEF.md
# Receive Descriptor Ring Consumer

This block drains a four-entry ring of receive descriptors kept in a small register-file store. Each entry has a 32-bit command/status word, a buffer pointer and a link word. The receive engine posts a finished frame into an entry by writing the status word with its ownership flag set, and it may also write the buffer pointer. It reads entries back through a peek port. The consumer watches only the entry at its current index. When that entry is owned, the consumer classifies the status flags. A frame that passes produces a good-frame event with the buffer index and the payload length. Any other frame produces an error event that carries the whole status word.

After either outcome, the consumer gives the entry back to the receiver. It rewrites the status word to the buffer size with ownership clear, restores the buffer pointer to its home address, steps the index with wraparound and issues a one-cycle receiver-on strobe. That strobe restarts a receive engine that may have gone idle for lack of free entries. The asynchronous active-low reset is released through a two-stage synchronizer.

Status word fields used by the block:
- bit 31: ownership
- bit 30: more fragments
- bit 27: packet OK
- bit 22: too long
- bits 11:0: received size

Top module: `rxr_ring_consumer`

## Requirements
- R1: After reset every entry holds status 0x600 (1536, ownership bit 31 clear) and buffer pointer BUF_BASE + i×1536, the current index is 0, and no event or strobe is active.
- R2: The link word of entry i reads DESC_BASE + ((i+1) mod 4)×16, so the last entry links back to entry 0.
- R3: While the current entry has bit 31 clear, the consumer raises no event and no strobe, leaves that entry's contents as written, and keeps its index. This holds even when a later entry is already owned.
- R4: An owned entry is a good frame only when, of bits 30, 27 and 22, bit 27 alone is set. The block then raises good_vld for one cycle, with good_idx equal to the entry's index.
- R5: For a good frame, good_len equals status bits 11:0 minus 4, taken modulo 2^12.
- R6: An owned entry that is not a good frame raises err_vld for one cycle, with err_status equal to the full 32-bit status word as posted.
- R7: After an entry is handled, good or bad, its status reads 0x600 and its buffer pointer reads its home address again, whatever pointer the receiver had written.
- R8: Each handled entry advances the current index by one, and the index wraps from 3 to 0. Entries are therefore handled in ring order.
- R9: rx_on pulses for exactly one cycle per handled entry, in the same cycle as that entry's good or error event.
- R10: The event appears in the third cycle after the receiver's write cycle when the consumer is already waiting on that entry. Back-to-back owned entries are handled one every two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| post_en | input | 1 | Receiver writes one entry this cycle |
| post_idx | input | 2 | Entry written by the receiver |
| post_status | input | 32 | Status word written by the receiver |
| post_bufptr | input | 32 | Buffer pointer written by the receiver |
| peek_idx | input | 2 | Entry read by the receiver |
| peek_status | output | 32 | Status word of the peeked entry |
| peek_bufptr | output | 32 | Buffer pointer of the peeked entry |
| peek_link | output | 32 | Link word of the peeked entry |
| cur_idx | output | 2 | Entry the consumer is watching |
| good_vld | output | 1 | Good-frame event |
| good_idx | output | 2 | Buffer index of the good frame |
| good_len | output | 12 | Payload length without the CRC |
| err_vld | output | 1 | Error-frame event |
| err_status | output | 32 | Full status word of the rejected entry |
| rx_on | output | 1 | Receiver restart strobe |

## Verification
A post is written into the store at the first clock edge after it is driven. The consumer captures the entry at the second edge and registers the event, the strobe and the recycle write at the third. Each scoreboard item therefore records the cycle count at drive time plus three. When the consumer meets owned entries already waiting, items are due two cycles apart. The monitor samples at the falling edge and checks both the content and the due cycle of every event it pops. Peek reads are combinational and are sampled shortly after a falling edge, once the handling edge has passed.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  // status word field positions
  localparam int OWN_BIT   = 31;
  localparam int MORE_BIT  = 30;
  localparam int OK_BIT    = 27;
  localparam int LONG_BIT  = 22;
  localparam int SIZE_W    = 12;
  localparam int CRC_BYTES = 4;

  typedef enum logic {
    WALK_WATCH  = 1'b0,
    WALK_RETIRE = 1'b1
  } walk_state_t;
endpackage

// File: rtl/rxr_desc_store.sv
module rxr_desc_store #(
  parameter int          DEPTH       = 4,
  parameter int          AW          = 2,
  parameter int          BUF_BYTES   = 1536,
  parameter logic [31:0] BUF_BASE    = 32'h0010_0000,
  parameter logic [31:0] DESC_BASE   = 32'h0000_8000,
  parameter int          DESC_STRIDE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          post_en,
  input  logic [AW-1:0] post_idx,
  input  logic [31:0]   post_status,
  input  logic [31:0]   post_bufptr,
  input  logic          rcl_en,
  input  logic [AW-1:0] rcl_idx,
  input  logic [AW-1:0] cons_idx,
  output logic [31:0]   cons_status,
  input  logic [AW-1:0] peek_idx,
  output logic [31:0]   peek_status,
  output logic [31:0]   peek_bufptr,
  output logic [31:0]   peek_link
);
  localparam logic [31:0] RECYCLE = 32'(BUF_BYTES);

  logic [31:0] st_a   [DEPTH];
  logic [31:0] buf_a  [DEPTH];
  logic [31:0] link_a [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam logic [31:0] HOME = BUF_BASE + 32'(i * BUF_BYTES);
    localparam logic [31:0] LINK = DESC_BASE + 32'(((i + 1) % DEPTH) * DESC_STRIDE);

    logic        rcl_hit, post_hit, we;
    logic [31:0] st_d, st_q, bp_d, bp_q;

    // recycle by the consumer takes priority over a receiver write
    always_comb begin
      rcl_hit  = rcl_en  && (rcl_idx  == AW'(i));
      post_hit = post_en && (post_idx == AW'(i));
      we       = rcl_hit || post_hit;
      st_d     = st_q;
      bp_d     = bp_q;
      if (rcl_hit) begin
        st_d = RECYCLE;
        bp_d = HOME;
      end else if (post_hit) begin
        st_d = post_status;
        bp_d = post_bufptr;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q <= RECYCLE;
        bp_q <= HOME;
      end else if (we) begin
        st_q <= st_d;
        bp_q <= bp_d;
      end
    end

    assign st_a[i]   = st_q;
    assign buf_a[i]  = bp_q;
    assign link_a[i] = LINK;
  end

  assign cons_status = st_a[cons_idx];
  assign peek_status = st_a[peek_idx];
  assign peek_bufptr = buf_a[peek_idx];
  assign peek_link   = link_a[peek_idx];

  function automatic logic [31:0] home_of(input logic [AW-1:0] idx);
    return BUF_BASE + 32'(idx) * 32'(BUF_BYTES);
  endfunction

  // R7: a handled entry reads back free with its home pointer
  p_recycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rcl_en |=> (st_a[$past(rcl_idx)] == RECYCLE) &&
               (buf_a[$past(rcl_idx)] == home_of($past(rcl_idx))));

  // R3: a receiver write not overridden lands unchanged
  p_post_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (post_en && !(rcl_en && rcl_idx == post_idx))
      |=> st_a[$past(post_idx)] == $past(post_status));
endmodule

// File: rtl/rxr_frame_judge.sv
module rxr_frame_judge
  import rxr_pkg::*;
(
  input  logic [31:0]       status,
  output logic              owned,
  output logic              good,
  output logic [SIZE_W-1:0] len
);
  always_comb begin
    owned = status[OWN_BIT];
    good  = status[OK_BIT] && !status[MORE_BIT] && !status[LONG_BIT];
    len   = status[SIZE_W-1:0] - SIZE_W'(CRC_BYTES);
  end
endmodule

// File: rtl/rxr_ring_walker.sv
module rxr_ring_walker
  import rxr_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              owned,
  input  logic              good,
  input  logic [SIZE_W-1:0] len,
  input  logic [31:0]       status,
  output logic [AW-1:0]     cur_idx,
  output logic              rcl_en,
  output logic [AW-1:0]     rcl_idx,
  output logic              good_vld,
  output logic [AW-1:0]     good_idx,
  output logic [SIZE_W-1:0] good_len,
  output logic              err_vld,
  output logic [31:0]       err_status,
  output logic              rx_on
);
  walk_state_t       st_q, st_d;
  logic [AW-1:0]     cur_q, cur_d, cur_inc;
  logic              sg_q;
  logic [SIZE_W-1:0] sl_q;
  logic [31:0]       ss_q;
  logic              gv_q, gv_d, ev_q, ev_d, ro_q, ro_d;
  logic [AW-1:0]     gi_q;
  logic [SIZE_W-1:0] gl_q;
  logic [31:0]       es_q;
  logic              cap_en, retire, good_ld, err_ld;

  // index step: free wrap for a power-of-two ring, compare otherwise
  if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
    assign cur_inc = cur_q + AW'(1);
  end else begin : g_wrap_cmp
    assign cur_inc = (cur_q == AW'(DEPTH - 1)) ? '0 : cur_q + AW'(1);
  end

  always_comb begin
    cap_en  = (st_q == WALK_WATCH) && owned;
    retire  = (st_q == WALK_RETIRE);
    st_d    = st_q;
    cur_d   = cur_q;
    case (st_q)
      WALK_WATCH:  if (owned) st_d = WALK_RETIRE;
      WALK_RETIRE: begin
        st_d  = WALK_WATCH;
        cur_d = cur_inc;
      end
      default:     st_d = WALK_WATCH;
    endcase
    gv_d    = retire && sg_q;
    ev_d    = retire && !sg_q;
    ro_d    = retire;
    good_ld = retire && sg_q;
    err_ld  = retire && !sg_q;
  end

  // state, index and one-cycle strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WALK_WATCH;
      cur_q <= '0;
      gv_q  <= 1'b0;
      ev_q  <= 1'b0;
      ro_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cur_q <= cur_d;
      gv_q  <= gv_d;
      ev_q  <= ev_d;
      ro_q  <= ro_d;
    end
  end

  // snapshot of the owned entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sg_q <= 1'b0;
      sl_q <= '0;
      ss_q <= '0;
    end else if (cap_en) begin
      sg_q <= good;
      sl_q <= len;
      ss_q <= status;
    end
  end

  // event payload registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gi_q <= '0;
      gl_q <= '0;
    end else if (good_ld) begin
      gi_q <= cur_q;
      gl_q <= sl_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) es_q <= '0;
    else if (err_ld) es_q <= ss_q;
  end

  assign cur_idx    = cur_q;
  assign rcl_en     = retire;
  assign rcl_idx    = cur_q;
  assign good_vld   = gv_q;
  assign good_idx   = gi_q;
  assign good_len   = gl_q;
  assign err_vld    = ev_q;
  assign err_status = es_q;
  assign rx_on      = ro_q;

  // R3: an unowned current entry holds the walk in place
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WALK_WATCH && !owned) |=> (cur_q == $past(cur_q)) && !ro_q);

  // R8: each strobe comes with a single ring step
  p_idx_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ro_q |-> cur_q == (($past(cur_q) == AW'(DEPTH - 1)) ? '0 : $past(cur_q) + AW'(1)));

  // R9: strobe and exactly one event coincide
  p_evt_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({gv_q, ev_q}) == 1) == ro_q);

  // R10: at most one handled entry every two cycles
  p_pace_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ro_q |=> !ro_q);
endmodule

// File: rtl/rxr_ring_consumer.sv
module rxr_ring_consumer
  import rxr_pkg::*;
#(
  parameter int          DEPTH       = 4,
  parameter int          BUF_BYTES   = 1536,
  parameter logic [31:0] BUF_BASE    = 32'h0010_0000,
  parameter logic [31:0] DESC_BASE   = 32'h0000_8000,
  parameter int          DESC_STRIDE = 16,
  localparam int         AW          = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              post_en,
  input  logic [AW-1:0]     post_idx,
  input  logic [31:0]       post_status,
  input  logic [31:0]       post_bufptr,
  input  logic [AW-1:0]     peek_idx,
  output logic [31:0]       peek_status,
  output logic [31:0]       peek_bufptr,
  output logic [31:0]       peek_link,
  output logic [AW-1:0]     cur_idx,
  output logic              good_vld,
  output logic [AW-1:0]     good_idx,
  output logic [SIZE_W-1:0] good_len,
  output logic              err_vld,
  output logic [31:0]       err_status,
  output logic              rx_on
);
  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  logic [31:0]       cons_status;
  logic              owned, good;
  logic [SIZE_W-1:0] len;
  logic              rcl_en;
  logic [AW-1:0]     rcl_idx;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  rxr_desc_store #(
    .DEPTH(DEPTH), .AW(AW), .BUF_BYTES(BUF_BYTES), .BUF_BASE(BUF_BASE),
    .DESC_BASE(DESC_BASE), .DESC_STRIDE(DESC_STRIDE)
  ) u_store (
    .clk(clk), .rst_n(core_rst_n),
    .post_en(post_en), .post_idx(post_idx),
    .post_status(post_status), .post_bufptr(post_bufptr),
    .rcl_en(rcl_en), .rcl_idx(rcl_idx),
    .cons_idx(cur_idx), .cons_status(cons_status),
    .peek_idx(peek_idx), .peek_status(peek_status),
    .peek_bufptr(peek_bufptr), .peek_link(peek_link)
  );

  rxr_frame_judge u_judge (
    .status(cons_status), .owned(owned), .good(good), .len(len)
  );

  rxr_ring_walker #(.DEPTH(DEPTH), .AW(AW)) u_walk (
    .clk(clk), .rst_n(core_rst_n),
    .owned(owned), .good(good), .len(len), .status(cons_status),
    .cur_idx(cur_idx), .rcl_en(rcl_en), .rcl_idx(rcl_idx),
    .good_vld(good_vld), .good_idx(good_idx), .good_len(good_len),
    .err_vld(err_vld), .err_status(err_status), .rx_on(rx_on)
  );

  // R4: a good event names the entry just left
  p_good_idx_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
    good_vld |-> good_idx == $past(cur_idx));

  // R6: rejected entries were owned when handled
  p_err_owned_r6: assert property (@(posedge clk) disable iff (!core_rst_n)
    err_vld |-> err_status[OWN_BIT]);
endmodule

// File: tb/sim_rxr_ring_consumer.sv
module sim_rxr_ring_consumer;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] BUF_BASE   = 32'h0010_0000;
  localparam logic [31:0] DESC_BASE  = 32'h0000_8000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        post_en = 1'b0;
  logic [1:0]  post_idx = '0;
  logic [31:0] post_status = '0;
  logic [31:0] post_bufptr = '0;
  logic [1:0]  peek_idx = '0;
  logic [31:0] peek_status, peek_bufptr, peek_link;
  logic [1:0]  cur_idx, good_idx;
  logic        good_vld, err_vld, rx_on;
  logic [11:0] good_len;
  logic [31:0] err_status;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rxr_ring_consumer #(.BUF_BASE(BUF_BASE), .DESC_BASE(DESC_BASE)) u0 (
    .clk(clk), .rst_n(rst_n),
    .post_en(post_en), .post_idx(post_idx),
    .post_status(post_status), .post_bufptr(post_bufptr),
    .peek_idx(peek_idx), .peek_status(peek_status),
    .peek_bufptr(peek_bufptr), .peek_link(peek_link),
    .cur_idx(cur_idx), .good_vld(good_vld), .good_idx(good_idx),
    .good_len(good_len), .err_vld(err_vld), .err_status(err_status),
    .rx_on(rx_on)
  );

  typedef struct {
    bit          good;
    int          idx;
    int          len;
    logic [31:0] st;
    int          due;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  int   cyc = 0;
  int   last_post = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] home(input int i);
    return BUF_BASE + 32'(i * 1536);
  endfunction

  // expectation derived from the requirements
  task automatic push_exp(input int idx, input logic [31:0] st, input int due);
    exp_t e;
    e.good = st[27] && !st[30] && !st[22];
    e.idx  = idx;
    e.len  = int'(st[11:0] - 12'd4);
    e.st   = st;
    e.due  = due;
    q.push_back(e);
  endtask

  task automatic post(input int idx, input logic [31:0] st, input logic [31:0] bp);
    @(negedge clk);
    post_en     = 1'b1;
    post_idx    = 2'(idx);
    post_status = st;
    post_bufptr = bp;
    last_post   = cyc;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    post_en = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic peek_chk(input int i, input logic [31:0] st, input logic [31:0] bp,
                          input string req);
    @(negedge clk);
    peek_idx = 2'(i);
    #1;
    chk(peek_status == st, req, "entry status", peek_status, st);
    chk(peek_bufptr == bp, req, "entry bufptr", peek_bufptr, bp);
  endtask

  // monitor: pops the scoreboard on every event
  always @(negedge clk) begin
    if (rst_n && (good_vld === 1'b1 || err_vld === 1'b1)) begin
      chk(rx_on === 1'b1, "R9", "strobe with event", 32'(rx_on), 32'd1);
      if (q.size() == 0) begin
        chk(1'b0, "R3", "unexpected event", 32'(good_vld), 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.due >= 0)
          chk(cyc == e.due, "R10", "event cycle", 32'(cyc), 32'(e.due));
        if (e.good) begin
          chk(good_vld === 1'b1 && err_vld === 1'b0, "R4", "good flag",
              {30'd0, good_vld, err_vld}, 32'd2);
          chk(good_idx == 2'(e.idx), "R8", "good index", 32'(good_idx), 32'(e.idx));
          chk(good_len == 12'(e.len), "R5", "length", 32'(good_len), 32'(e.len));
        end else begin
          chk(err_vld === 1'b1 && good_vld === 1'b0, "R6", "error flag",
              {30'd0, good_vld, err_vld}, 32'd1);
          chk(err_status == e.st, "R6", "error status", err_status, e.st);
        end
      end
    end else if (rst_n && rx_on === 1'b1) begin
      chk(1'b0, "R9", "strobe without event", 32'd1, 32'd0);
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1, R2: reset contents and ring links
    for (int i = 0; i < 4; i++) begin
      peek_chk(i, 32'h600, home(i), "R1");
      chk(peek_link == DESC_BASE + 32'(((i + 1) % 4) * 16), "R2", "link",
          peek_link, DESC_BASE + 32'(((i + 1) % 4) * 16));
    end
    chk(cur_idx == 2'd0, "R1", "index", 32'(cur_idx), 32'd0);
    chk(!good_vld && !err_vld && !rx_on, "R1", "quiet outputs",
        {29'd0, good_vld, err_vld, rx_on}, 32'd0);

    // R4, R5, R7: good frame with a corrupted pointer
    post(0, 32'h8800_0064, 32'hDEAD_0000);
    push_exp(0, 32'h8800_0064, last_post + 3);
    idle(5);
    peek_chk(0, 32'h600, home(0), "R7");
    chk(cur_idx == 2'd1, "R8", "index after one", 32'(cur_idx), 32'd1);

    // R6: more-fragments, too-long, and missing packet-OK
    post(1, 32'hC800_0040, 32'h1234_5678);
    push_exp(1, 32'hC800_0040, last_post + 3);
    idle(5);
    post(2, 32'h8840_07D0, home(2));
    push_exp(2, 32'h8840_07D0, last_post + 3);
    idle(5);
    post(3, 32'h8008_003C, 32'h0);
    push_exp(3, 32'h8008_003C, last_post + 3);
    idle(5);
    peek_chk(3, 32'h600, home(3), "R7");
    chk(cur_idx == 2'd0, "R8", "wrap to zero", 32'(cur_idx), 32'd0);

    // R3: current entry written without ownership
    post(0, 32'h0800_0050, 32'hAAAA_0000);
    idle(8);
    chk(cur_idx == 2'd0, "R3", "index held", 32'(cur_idx), 32'd0);
    peek_chk(0, 32'h0800_0050, 32'hAAAA_0000, "R3");

    // R3: a later owned entry does not pull the walk ahead
    post(1, 32'h8800_00C8, 32'h0);
    idle(8);
    chk(cur_idx == 2'd0, "R3", "index held with later owned", 32'(cur_idx), 32'd0);

    // R10: once entry 0 is posted, entry 1 follows two cycles later
    post(0, 32'h8800_0040, home(0));
    d = last_post + 3;
    push_exp(0, 32'h8800_0040, d);
    push_exp(1, 32'h8800_00C8, d + 2);
    idle(8);
    chk(cur_idx == 2'd2, "R8", "index after pair", 32'(cur_idx), 32'd2);

    // burst: one post per cycle, sizes at the length extremes
    post(2, 32'h8800_05F2, 32'hBEEF_0002);
    d = last_post + 3;
    push_exp(2, 32'h8800_05F2, d);
    post(3, 32'h8840_0100, 32'hBEEF_0003);
    push_exp(3, 32'h8840_0100, d + 2);
    post(0, 32'h8800_0004, 32'hBEEF_0000);
    push_exp(0, 32'h8800_0004, d + 4);
    post(1, 32'h8800_0FFF, 32'hBEEF_0001);
    push_exp(1, 32'h8800_0FFF, d + 6);
    idle(14);
    for (int i = 0; i < 4; i++) peek_chk(i, 32'h600, home(i), "R7");
    chk(cur_idx == 2'd2, "R8", "index after burst", 32'(cur_idx), 32'd2);
    chk(q.size() == 0, "R9", "all events seen", 32'(q.size()), 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule